// File: doc/BRIEF.md
# Neural network ADC post-corrector

This block cleans up the output of a 9-bit analog-to-digital converter as the samples stream past. Each accepted sample is paired with the sample accepted before it. Both codes go through a small feed-forward network, and the network's answer is added back onto the raw code. The network has two inputs, one or two hidden layers of parameterised width, and a single linear output neuron. Every neuron has its own multipliers and adder, so a new sample can enter on every clock.

The network's weights and biases sit in a coefficient bank. They are written through a plain address/data/enable port, and the bank clears to zero on reset. With an all-zero bank the block passes the raw code through unchanged. Training of the coefficients is done elsewhere.

All network arithmetic is signed fixed point in a 16-bit word: one sign bit, five integer bits and nine fractional bits. The hidden neurons use a piecewise-quadratic squashing function by default. A saturating linear function can be chosen by parameter.

Top module: `nnc_corrector`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_valid is 0 and out_code is 0. Every coefficient clears to 0 on reset.
- R2: out_valid goes high exactly LAT clock edges after an edge that accepts in_valid. LAT is 3 with one hidden layer and 4 with two. With every coefficient at 0, out_code equals the accepted in_code.
- R3: A code c enters the network as the fixed-point value (c - 256)/256, held as the raw word (c - 256)*2. Code 256 therefore maps to 0, and code 384 maps to 0.5 (raw word 256).
- R4: The second network input is the code accepted most recently before the current one, or mid-scale 256 after reset. The stored previous code changes only when a sample is accepted.
- R5: Coefficient addresses for the default single hidden layer of 10 neurons are laid out as follows:
  - Hidden neuron j: address 3j is the weight on the current code, address 3j+1 is the weight on the previous code, and address 3j+2 is the bias.
  - Output neuron: address 30+j is the weight on hidden neuron j, and address 40 is the bias.
  - With a second hidden layer, each of its neurons takes one weight per first-layer neuron followed by one bias. This group sits between the first layer and the output neuron.
- R6: The default hidden activation maps x to:
  - -1 for x < -2;
  - x(1 + x/4) for -2 <= x < 0;
  - x(1 - x/4) for 0 <= x <= 2;
  - +1 for x > 2.
  For example, an input of 0.5 gives 0.4375 (raw 224). The output neuron is the identity.
- R7: Each product is rounded to nine fractional bits, with a half rounding upward, and saturated to the 16-bit range. Each neuron sum, including its bias, saturates to the 16-bit range instead of wrapping.
- R8: The correction in codes is the output neuron value times 256, rounded with a half going upward. For example, raw 1 gives +1 and raw -1 gives 0. The corrected sum is clamped to 0..511.
- R9: A coefficient write is visible to a sample accepted on any later cycle. A write to an address of 41 or above (default map) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new ADC sample is present on in_code |
| in_code | input | ADC_W | Raw ADC code, unsigned |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | ADDR_W | Coefficient address |
| wr_data | input | 16 | Coefficient value, signed fixed point with 9 fractional bits |
| out_valid | output | 1 | out_code holds a corrected sample |
| out_code | output | ADC_W | Corrected and clamped ADC code |

## Verification
Each pattern isolates one part of the datapath.
- An all-zero bank, driven with codes at both ends of the range, separates the bare pass-through and latency from any network effect.
- An output-bias-only setup exercises the final rounding and both clamps without touching the hidden layer.
- Single-path setups separate the mid-scale centring from the squashing curve and its saturated tails. Each routes one input through one hidden neuron, either the first or the last of the layer.
- A weight on the previous code only tells correct sample ordering apart from a delay line that is off by one.
- A large bias combined with a large weight shows whether the neuron sum saturates or wraps.

// File: rtl/nnc_pkg.sv
package nnc_pkg;

    localparam int FX_W    = 16;
    localparam int FX_FRAC = 9;

    typedef logic signed [FX_W-1:0] fx_t;

    typedef enum logic [1:0] {
        ACT_SIG,
        ACT_LIN,
        ACT_ID
    } act_e;

    localparam fx_t FX_ONE = fx_t'(1 <<< FX_FRAC);
    localparam fx_t FX_MAX = fx_t'((1 <<< (FX_W - 1)) - 1);
    localparam fx_t FX_MIN = fx_t'(-(1 <<< (FX_W - 1)));

    function automatic fx_t fx_sat(input logic signed [39:0] v);
        if (v > 40'(FX_MAX))
            return FX_MAX;
        else if (v < 40'(FX_MIN))
            return FX_MIN;
        else
            return fx_t'(v);
    endfunction

    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [2*FX_W-1:0] p;
        p = (2*FX_W)'(a) * (2*FX_W)'(b);
        p = p + (2*FX_W)'(1 <<< (FX_FRAC - 1));
        return fx_sat(40'(p >>> FX_FRAC));
    endfunction

endpackage

// File: rtl/nnc_coef_bank.sv
module nnc_coef_bank
    import nnc_pkg::*;
#(
    parameter int NCOEF  = 41,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  fx_t                     wr_data,
    output logic [NCOEF*FX_W-1:0]   coef
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NCOEF);

    always_ff @(posedge clk) begin
        if (rst) begin
            coef <= '0;
        end else if (wr_en && ({1'b0, wr_addr} < LIMIT)) begin
            coef[FX_W*int'(wr_addr) +: FX_W] <= wr_data;
        end
    end

endmodule

// File: rtl/nnc_act.sv
module nnc_act
    import nnc_pkg::*;
#(
    parameter act_e ACT = ACT_SIG
) (
    input  fx_t x,
    output fx_t y
);

    localparam fx_t TWO = fx_t'(2 <<< FX_FRAC);

    generate
        if (ACT == ACT_LIN) begin : g_lin
            always_comb begin
                if (x > FX_ONE)
                    y = FX_ONE;
                else if (x < -FX_ONE)
                    y = -FX_ONE;
                else
                    y = x;
            end
        end else begin : g_sig
            logic signed [FX_W:0]   m;
            logic signed [2*FX_W:0] p;
            always_comb begin
                if (x >= 0)
                    m = (FX_W+1)'(FX_ONE) - (FX_W+1)'(x >>> 2);
                else
                    m = (FX_W+1)'(FX_ONE) + (FX_W+1)'(x >>> 2);
                p = (2*FX_W+1)'(x) * (2*FX_W+1)'(m);
                if (x > TWO)
                    y = FX_ONE;
                else if (x < -TWO)
                    y = -FX_ONE;
                else
                    y = fx_t'(p >>> FX_FRAC);
            end
        end
    endgenerate

endmodule

// File: rtl/nnc_neuron.sv
module nnc_neuron
    import nnc_pkg::*;
#(
    parameter int   N_IN = 2,
    parameter act_e ACT  = ACT_SIG
) (
    input  logic [N_IN*FX_W-1:0]     u,
    input  logic [(N_IN+1)*FX_W-1:0] cw,
    output fx_t                      y
);

    localparam int SW = FX_W + $clog2(N_IN + 2);

    fx_t                 prod [N_IN];
    logic signed [SW-1:0] acc;
    fx_t                 pre;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_mul
            assign prod[i] = fx_mul(fx_t'(cw[i*FX_W +: FX_W]), fx_t'(u[i*FX_W +: FX_W]));
        end
    endgenerate

    always_comb begin
        acc = SW'(fx_t'(cw[N_IN*FX_W +: FX_W]));
        for (int i = 0; i < N_IN; i++) begin
            acc = acc + SW'(prod[i]);
        end
        pre = fx_sat(40'(acc));
    end

    generate
        if (ACT == ACT_ID) begin : g_id
            assign y = pre;
        end else begin : g_act
            nnc_act #(.ACT(ACT)) u_act (
                .x(pre),
                .y(y)
            );
        end
    endgenerate

endmodule

// File: rtl/nnc_corrector.sv
module nnc_corrector
    import nnc_pkg::*;
#(
    parameter int   ADC_W  = 9,
    parameter int   N_H1   = 10,
    parameter int   N_H2   = 0,
    parameter act_e ACT    = ACT_SIG,
    parameter int   ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADC_W-1:0]  in_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic              out_valid,
    output logic [ADC_W-1:0]  out_code
);

    localparam int NL       = (N_H2 > 0) ? 2 : 1;
    localparam int LAT      = NL + 2;
    localparam int N_LAST   = (N_H2 > 0) ? N_H2 : N_H1;
    localparam int L2_BASE  = N_H1 * 3;
    localparam int OUT_BASE = L2_BASE + ((N_H2 > 0) ? N_H2 * (N_H1 + 1) : 0);
    localparam int NCOEF    = OUT_BASE + N_LAST + 1;
    localparam int SH       = FX_FRAC - (ADC_W - 1);
    localparam logic [ADC_W-1:0] MID = ADC_W'(1 << (ADC_W - 1));
    localparam logic signed [FX_W+1:0] CMAX = (FX_W+2)'((1 << ADC_W) - 1);

    function automatic fx_t centre(input logic [ADC_W-1:0] c);
        logic signed [ADC_W:0] d;
        fx_t t;
        d = $signed({1'b0, c}) - $signed({1'b0, MID});
        t = fx_t'(d);
        return t <<< SH;
    endfunction

    logic [NCOEF*FX_W-1:0] coef;

    nnc_coef_bank #(.NCOEF(NCOEF), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk),
        .rst(rst),
        .wr_en(wr_en),
        .wr_addr(wr_addr),
        .wr_data(fx_t'(wr_data)),
        .coef(coef)
    );

    // Input stage: centred current and previous codes.
    logic [ADC_W-1:0]    prev_code;
    logic [2*FX_W-1:0]   u0;
    logic [ADC_W-1:0]    raw_p [NL+1];
    logic [NL:0]         vld_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_code <= MID;
            u0        <= '0;
            raw_p[0]  <= '0;
            vld_p[0]  <= 1'b0;
        end else begin
            vld_p[0] <= in_valid;
            if (in_valid) begin
                prev_code <= in_code;
                u0        <= {centre(prev_code), centre(in_code)};
                raw_p[0]  <= in_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k <= NL; k++) begin
                raw_p[k] <= '0;
                vld_p[k] <= 1'b0;
            end
        end else begin
            for (int k = 1; k <= NL; k++) begin
                raw_p[k] <= raw_p[k-1];
                vld_p[k] <= vld_p[k-1];
            end
        end
    end

    // First hidden layer.
    logic [N_H1*FX_W-1:0] h1_d, h1_q;

    generate
        for (genvar j = 0; j < N_H1; j++) begin : g_h1
            nnc_neuron #(.N_IN(2), .ACT(ACT)) u_n (
                .u(u0),
                .cw(coef[j*3*FX_W +: 3*FX_W]),
                .y(h1_d[j*FX_W +: FX_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) h1_q <= '0;
        else     h1_q <= h1_d;
    end

    // Optional second hidden layer.
    logic [N_LAST*FX_W-1:0] hl;

    generate
        if (N_H2 > 0) begin : g_l2
            logic [N_H2*FX_W-1:0] h2_d, h2_q;
            for (genvar j = 0; j < N_H2; j++) begin : g_h2
                nnc_neuron #(.N_IN(N_H1), .ACT(ACT)) u_n (
                    .u(h1_q),
                    .cw(coef[(L2_BASE + j*(N_H1+1))*FX_W +: (N_H1+1)*FX_W]),
                    .y(h2_d[j*FX_W +: FX_W])
                );
            end
            always_ff @(posedge clk) begin
                if (rst) h2_q <= '0;
                else     h2_q <= h2_d;
            end
            assign hl = h2_q;
        end else begin : g_l1
            assign hl = h1_q;
        end
    endgenerate

    // Output neuron, correction and clamp.
    fx_t                      y;
    logic signed [FX_W:0]     corr;
    logic signed [FX_W+1:0]   tot;
    logic [ADC_W-1:0]         clamped;

    nnc_neuron #(.N_IN(N_LAST), .ACT(ACT_ID)) u_out (
        .u(hl),
        .cw(coef[OUT_BASE*FX_W +: (N_LAST+1)*FX_W]),
        .y(y)
    );

    always_comb begin
        corr = ((FX_W+1)'(y) + (FX_W+1)'(1 <<< (SH - 1))) >>> SH;
        tot  = (FX_W+2)'(corr) + (FX_W+2)'($signed({1'b0, raw_p[NL]}));
        if (tot < 0)
            clamped = '0;
        else if (tot > CMAX)
            clamped = CMAX[ADC_W-1:0];
        else
            clamped = tot[ADC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= vld_p[NL];
            if (vld_p[NL]) out_code <= clamped;
        end
    end

endmodule

// File: rtl/nnc_corrector_chk.sv
module nnc_corrector_chk #(
    parameter int ADC_W = 9,
    parameter int LAT   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [ADC_W-1:0] in_code,
    input logic             out_valid,
    input logic [ADC_W-1:0] out_code,
    input logic [ADC_W-1:0] prev_code
);

    logic [LAT-1:0] vsh;

    always_ff @(posedge clk) begin
        if (rst) vsh <= '0;
        else     vsh <= {vsh[LAT-2:0], in_valid};
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_code == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsh[LAT-1]);

    // R4
    prev_track_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prev_code == $past(in_code));

    // R4
    prev_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prev_code));

endmodule

bind nnc_corrector nnc_corrector_chk #(.ADC_W(ADC_W), .LAT(LAT)) i_chk (
    .clk(clk),
    .rst(rst),
    .in_valid(in_valid),
    .in_code(in_code),
    .out_valid(out_valid),
    .out_code(out_code),
    .prev_code(prev_code)
);

// File: tb/test_nnc_corrector.sv
module test_nnc_corrector;

    localparam int LAT   = 3;
    localparam int NCOEF = 41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  in_code = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_valid;
    logic [8:0]  out_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nnc_corrector i_nnc_corrector (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_code(in_code),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int a = 0; a < NCOEF; a++) wr(a, 0);
    endtask

    // Sends one sample, checks the latency (R2) and returns the result.
    task automatic run(input int code, output int got);
        @(negedge clk);
        in_valid = 1'b1; in_code = 9'(code);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        check("R2 valid early", int'(out_valid), 0);
        @(negedge clk);
        check("R2 valid at latency", int'(out_valid), 1);
        got = int'(out_code);
    endtask

    task automatic t_reset();
        int g;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 code in reset", int'(out_code), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 code after reset", int'(out_code), 0);
        run(100, g);
        check("R1 zero coefficients", g, 100);
    endtask

    task automatic t_passthrough();
        int g;
        run(0, g);   check("R2 pass 0", g, 0);
        run(511, g); check("R2 pass 511", g, 511);
        run(37, g);  check("R2 pass 37", g, 37);
    endtask

    task automatic t_out_bias();
        int g;
        clear_all();
        wr(40, 256);
        run(200, g); check("R8 bias +0.5", g, 328);
        run(450, g); check("R8 clamp high", g, 511);
        wr(40, -256);
        run(100, g); check("R8 clamp low", g, 0);
        wr(40, 1);
        run(10, g);  check("R8 round +half", g, 11);
        wr(40, -1);
        run(10, g);  check("R8 round -half", g, 10);
    endtask

    task automatic t_sig();
        int g;
        clear_all();
        wr(0, 512); wr(30, 512);
        run(384, g); check("R6 R3 sig +0.5", g, 496);
        run(128, g); check("R6 R3 sig -0.5", g, 16);
        run(256, g); check("R3 mid-scale zero", g, 256);
        wr(0, 4096); wr(30, 128);
        run(400, g); check("R6 sat +1", g, 464);
        run(112, g); check("R6 sat -1", g, 48);
        clear_all();
        wr(27, 512); wr(39, 512);
        run(384, g); check("R5 last hidden neuron", g, 496);
    endtask

    task automatic t_prev();
        int g;
        clear_all();
        wr(4, 512); wr(31, 512);
        run(256, g);
        run(384, g); check("R4 prev mid", g, 384);
        run(256, g); check("R4 prev 384", g, 368);
        run(128, g); check("R4 prev 256", g, 128);
    endtask

    task automatic t_sat();
        int g;
        clear_all();
        wr(0, 32767); wr(2, 32767); wr(30, 128);
        run(300, g); check("R7 sum saturates", g, 364);
    endtask

    task automatic t_write();
        int g;
        clear_all();
        wr(250, 16384);
        run(77, g); check("R9 out-of-range ignored", g, 77);
        wr(40, 256);
        run(77, g); check("R9 write seen next sample", g, 205);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_out_bias();
        t_sig();
        t_prev();
        t_sat();
        t_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule